// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block produces ten active-low chip selects for a 20-bit memory space and a 16-bit I/O space. Every channel holds three programmable words: a 10-bit lower window limit, a 10-bit upper window limit, and a control word. The control word sets the channel's enable, its address space, its wait-state count and whether the external READY input is honoured. When a bus cycle begins, the block latches the address. It compares the address with every window and registers one select per matching channel. It then times the cycle. It either inserts a fixed number of wait states and ends the cycle by itself, or it inserts wait states and then waits for READY.

Windows may overlap, and every matching channel asserts. The timing of the cycle is then resolved from all matching channels together. If any matching channel honours READY, the cycle uses the smallest wait count among them and then samples READY. If none does, the cycle uses the largest count and finishes without READY. A 256-byte peripheral block window, placed by an input base and an input space bit, suppresses every select inside it.

The cycle sequencer has five states:
- IDLE waits for the address strobe.
- DECODE registers the selects and the resolved policy.
- WAIT counts the inserted wait states.
- SAMPLE holds until READY is high.
- FINISH raises `cyc_done` for one clock and releases the selects.

The transitions are:
- IDLE to DECODE on the strobe.
- DECODE to WAIT when the count is non-zero.
- DECODE to SAMPLE on a zero count with READY honoured.
- DECODE to FINISH on a zero count with READY ignored.
- WAIT to SAMPLE or to FINISH when the count expires, chosen by the policy.
- SAMPLE to FINISH on READY.
- FINISH to IDLE always.

Top module: `chip_select_decoder`

## Requirements
- R1: After reset every `cs_n` bit is high and `cyc_done` is low. Only channel 9 is enabled, covering memory 0xFFC00 to 0xFFFFF with READY honoured and 3 wait states. All other channels are disabled.
- R2: A write with `cfg_we` high updates channel `cfg_chan` according to `cfg_field`: 0 sets the lower limit from `cfg_wdata[9:0]`, 1 sets the upper limit from `cfg_wdata[9:0]`, and 2 sets the control word. Field code 3 changes nothing. Control word bits: bit 0 enable, bit 1 I/O space (1) or memory space (0), bit 2 honour READY, bits 7:4 wait-state count.
- R3: A memory cycle matches a channel when `cyc_addr[19:10]` lies between its lower and upper limit, both limits included.
- R4: An I/O cycle (`cyc_io` high) compares `cyc_addr[15:6]` instead. A channel matches only cycles in its own space.
- R5: A channel whose lower limit exceeds its upper limit, or whose enable is clear, never asserts.
- R6: All channels whose windows contain the address assert together.
- R7: If any matching channel honours READY, the cycle inserts the minimum wait count among the matching channels. It then waits, without limit, for READY high.
- R8: If matching channels exist and none honours READY, the cycle inserts the maximum wait count among them and finishes without looking at READY.
- R9: A cycle that matches no channel honours READY with zero wait states.
- R10: No select asserts for an address inside the 256-byte peripheral window. For memory the window is selected by `cyc_addr[19:8] == pcb_base`; for I/O it is selected by `cyc_addr[15:8] == pcb_base[7:0]`. The window applies only when `cyc_io` equals `pcb_io`.
- R11: Let the strobe be sampled at edge E0. The selects change at edge E1 and hold until `cyc_done`. `cyc_done` is high for one clock, at the E(1+w) edge when READY is ignored. When READY is honoured it comes at the later of the E(2+w) edge and the edge after READY is first seen high from SAMPLE. The selects release on the edge that ends `cyc_done`.
- R12: A strobe presented while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_chan | input | 4 | Channel index for a write |
| cfg_field | input | 2 | Word selector for a write |
| cfg_wdata | input | 16 | Write data |
| pcb_base | input | 12 | Base of the 256-byte peripheral window |
| pcb_io | input | 1 | Space of the peripheral window (1 = I/O) |
| cyc_strobe | input | 1 | Address strobe, starts a cycle |
| cyc_addr | input | 20 | Cycle address |
| cyc_io | input | 1 | Cycle space (1 = I/O) |
| ext_ready | input | 1 | External READY |
| cs_n | output | 10 | Active-low chip selects |
| cyc_done | output | 1 | One-clock cycle termination |

## Verification
The bench probes the window edges, both inclusive limits, and the bytes on either side of the peripheral window. A design with an off-by-one compare, or a design that masks the wrong address bits, would drop or add a select there. Overlapping windows with mixed READY policies are measured in clocks. Picking the minimum and maximum the wrong way round shows up as a cycle of the wrong length. So does a design that still waits for READY when every matching window ignores it.

Inverted-limit and disabled channels are placed where a wrap-around compare would wrongly hit. A cycle with READY held low must never finish. A strobe issued mid-cycle must neither restart decoding nor leave a stray cycle behind.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int WS_W = 4;

    typedef struct packed {
        logic [WS_W-1:0] ws;
        logic            use_rdy;
        logic            io;
        logic            en;
    } ch_ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_WAIT,
        S_SAMPLE,
        S_FINISH
    } seq_state_t;

    localparam logic [1:0] FLD_LO   = 2'd0;
    localparam logic [1:0] FLD_HI   = 2'd1;
    localparam logic [1:0] FLD_CTRL = 2'd2;

endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
    import csd_pkg::*;
#(
    parameter int NCH      = 10,
    parameter int TAGW     = 10,
    parameter int CFG_W    = 16,
    parameter int BOOT_CH  = 9,
    parameter int BOOT_WS  = 3,
    localparam int CHW     = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CHW-1:0]       chan,
    input  logic [1:0]           field,
    input  logic [CFG_W-1:0]     wdata,
    output logic [TAGW-1:0]      lo_o   [NCH],
    output logic [TAGW-1:0]      hi_o   [NCH],
    output ch_ctrl_t             ctrl_o [NCH]
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam bit IS_BOOT = (i == BOOT_CH);
        localparam logic [TAGW-1:0] RST_LO = IS_BOOT ? {TAGW{1'b1}} : '0;
        localparam logic [TAGW-1:0] RST_HI = IS_BOOT ? {TAGW{1'b1}} : '0;
        localparam ch_ctrl_t RST_CTRL = IS_BOOT ?
            '{ws: WS_W'(BOOT_WS), use_rdy: 1'b1, io: 1'b0, en: 1'b1} :
            '{ws: '0, use_rdy: 1'b0, io: 1'b0, en: 1'b0};

        logic [TAGW-1:0] lo_q;
        logic [TAGW-1:0] hi_q;
        ch_ctrl_t        ctrl_q;
        logic            sel;

        assign sel = we && (chan == CHW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q   <= RST_LO;
                hi_q   <= RST_HI;
                ctrl_q <= RST_CTRL;
            end else if (sel) begin
                case (field)
                    FLD_LO:   lo_q <= wdata[TAGW-1:0];
                    FLD_HI:   hi_q <= wdata[TAGW-1:0];
                    FLD_CTRL: begin
                        ctrl_q.en      <= wdata[0];
                        ctrl_q.io      <= wdata[1];
                        ctrl_q.use_rdy <= wdata[2];
                        ctrl_q.ws      <= wdata[4 +: WS_W];
                    end
                    default: ;
                endcase
            end
        end

        assign lo_o[i]   = lo_q;
        assign hi_o[i]   = hi_q;
        assign ctrl_o[i] = ctrl_q;
    end

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int NCH   = 10,
    parameter int AW    = 20,
    parameter int IOW   = 16,
    parameter int TAGW  = 10,
    parameter int PCB_W = 8,
    localparam int PBW  = AW - PCB_W
) (
    input  logic [AW-1:0]   addr_q,
    input  logic            io_q,
    input  logic [PBW-1:0]  pcb_base,
    input  logic            pcb_io,
    input  logic [TAGW-1:0] lo_i   [NCH],
    input  logic [TAGW-1:0] hi_i   [NCH],
    input  ch_ctrl_t        ctrl_i [NCH],
    output logic [NCH-1:0]  hit,
    output logic            pcb_hit
);

    localparam int IO_PBW = IOW - PCB_W;

    logic [TAGW-1:0] tag;
    logic            pcb_mem_eq;
    logic            pcb_io_eq;

    assign tag        = io_q ? addr_q[IOW-1 -: TAGW] : addr_q[AW-1 -: TAGW];
    assign pcb_mem_eq = (addr_q[AW-1:PCB_W] == pcb_base);
    assign pcb_io_eq  = (addr_q[IOW-1:PCB_W] == pcb_base[IO_PBW-1:0]);
    assign pcb_hit    = (pcb_io == io_q) && (io_q ? pcb_io_eq : pcb_mem_eq);

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic in_win;
        assign in_win = (lo_i[i] <= tag) && (tag <= hi_i[i]);
        assign hit[i] = ctrl_i[i].en && (ctrl_i[i].io == io_q) && in_win && !pcb_hit;
    end

endmodule

// File: rtl/csd_resolve.sv
module csd_resolve
    import csd_pkg::*;
#(
    parameter int NCH = 10
) (
    input  logic [NCH-1:0]  hit,
    input  ch_ctrl_t        ctrl_i [NCH],
    output logic            use_rdy,
    output logic [WS_W-1:0] ws
);

    logic            any_rdy;
    logic [WS_W-1:0] ws_min;
    logic [WS_W-1:0] ws_max;

    always_comb begin
        any_rdy = 1'b0;
        ws_min  = '1;
        ws_max  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                if (ctrl_i[i].use_rdy) any_rdy = 1'b1;
                if (ctrl_i[i].ws < ws_min) ws_min = ctrl_i[i].ws;
                if (ctrl_i[i].ws > ws_max) ws_max = ctrl_i[i].ws;
            end
        end
    end

    always_comb begin
        if (hit == '0) begin
            use_rdy = 1'b1;
            ws      = '0;
        end else if (any_rdy) begin
            use_rdy = 1'b1;
            ws      = ws_min;
        end else begin
            use_rdy = 1'b0;
            ws      = ws_max;
        end
    end

endmodule

// File: rtl/csd_seq.sv
module csd_seq
    import csd_pkg::*;
#(
    parameter int NCH = 10,
    parameter int AW  = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic [AW-1:0]   addr_in,
    input  logic            io_in,
    input  logic            ext_ready,
    input  logic [NCH-1:0]  hit,
    input  logic            use_rdy_in,
    input  logic [WS_W-1:0] ws_in,
    output logic [AW-1:0]   addr_q,
    output logic            io_q,
    output logic [NCH-1:0]  cs_n,
    output logic            cyc_done,
    output seq_state_t      state_o
);

    seq_state_t      state;
    seq_state_t      state_nx;
    logic [WS_W-1:0] wcnt;
    logic            rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (strobe) state_nx = S_DECODE;
            S_DECODE: begin
                if (ws_in != '0)     state_nx = S_WAIT;
                else if (use_rdy_in) state_nx = S_SAMPLE;
                else                 state_nx = S_FINISH;
            end
            S_WAIT:   if (wcnt == WS_W'(1)) state_nx = rdy_q ? S_SAMPLE : S_FINISH;
            S_SAMPLE: if (ext_ready) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            io_q   <= 1'b0;
            cs_n   <= '1;
            wcnt   <= '0;
            rdy_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (strobe) begin
                    addr_q <= addr_in;
                    io_q   <= io_in;
                end
                S_DECODE: begin
                    cs_n  <= ~hit;
                    wcnt  <= ws_in;
                    rdy_q <= use_rdy_in;
                end
                S_WAIT:   wcnt <= wcnt - WS_W'(1);
                S_SAMPLE: ;
                S_FINISH: cs_n <= '1;
                default:  ;
            endcase
        end
    end

    assign cyc_done = (state == S_FINISH);
    assign state_o  = state;

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
    import csd_pkg::*;
#(
    parameter int NCH     = 10,
    parameter int AW      = 20,
    parameter int IOW     = 16,
    parameter int TAGW    = 10,
    parameter int PCB_W   = 8,
    parameter int CFG_W   = 16,
    parameter int BOOT_WS = 3,
    localparam int CHW    = $clog2(NCH),
    localparam int PBW    = AW - PCB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CHW-1:0]   cfg_chan,
    input  logic [1:0]       cfg_field,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [PBW-1:0]   pcb_base,
    input  logic             pcb_io,
    input  logic             cyc_strobe,
    input  logic [AW-1:0]    cyc_addr,
    input  logic             cyc_io,
    input  logic             ext_ready,
    output logic [NCH-1:0]   cs_n,
    output logic             cyc_done
);

    logic [TAGW-1:0] lo_w   [NCH];
    logic [TAGW-1:0] hi_w   [NCH];
    ch_ctrl_t        ctrl_w [NCH];
    logic [AW-1:0]   addr_q;
    logic            io_q;
    logic [NCH-1:0]  hit_vec;
    logic            pcb_hit;
    logic            use_rdy;
    logic [WS_W-1:0] ws_res;
    seq_state_t      seq_state;

    csd_regfile #(
        .NCH(NCH), .TAGW(TAGW), .CFG_W(CFG_W),
        .BOOT_CH(NCH - 1), .BOOT_WS(BOOT_WS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .chan(cfg_chan),
        .field(cfg_field), .wdata(cfg_wdata),
        .lo_o(lo_w), .hi_o(hi_w), .ctrl_o(ctrl_w)
    );

    csd_match #(
        .NCH(NCH), .AW(AW), .IOW(IOW), .TAGW(TAGW), .PCB_W(PCB_W)
    ) u_match (
        .addr_q(addr_q), .io_q(io_q), .pcb_base(pcb_base), .pcb_io(pcb_io),
        .lo_i(lo_w), .hi_i(hi_w), .ctrl_i(ctrl_w),
        .hit(hit_vec), .pcb_hit(pcb_hit)
    );

    csd_resolve #(.NCH(NCH)) u_resolve (
        .hit(hit_vec), .ctrl_i(ctrl_w), .use_rdy(use_rdy), .ws(ws_res)
    );

    csd_seq #(.NCH(NCH), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe(cyc_strobe),
        .addr_in(cyc_addr), .io_in(cyc_io), .ext_ready(ext_ready),
        .hit(hit_vec), .use_rdy_in(use_rdy), .ws_in(ws_res),
        .addr_q(addr_q), .io_q(io_q), .cs_n(cs_n), .cyc_done(cyc_done),
        .state_o(seq_state)
    );

endmodule

// File: rtl/csd_checker.sv
module csd_checker
    import csd_pkg::*;
#(
    parameter int NCH = 10,
    parameter int AW  = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  cs_n,
    input logic            cyc_done,
    input logic            cyc_strobe,
    input seq_state_t      seq_state,
    input logic [NCH-1:0]  hit_vec,
    input logic            pcb_hit,
    input logic            use_rdy,
    input logic [WS_W-1:0] ws_res,
    input logic [AW-1:0]   addr_q
);

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> ((&cs_n) && !cyc_done));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_done && !(&cs_n)) |=> $stable(cs_n));

    p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_IDLE && cyc_strobe) |=> (seq_state == S_DECODE));

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != S_IDLE) |=> $stable(addr_q));

    p_nomatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_DECODE && hit_vec == '0) |=> (seq_state == S_SAMPLE));

    p_pcb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_DECODE && pcb_hit) |=> (&cs_n));

    p_ignore_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == S_DECODE && hit_vec != '0 && !use_rdy && ws_res == '0) |=> cyc_done);

endmodule

bind chip_select_decoder csd_checker #(.NCH(NCH), .AW(AW)) u_csd_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cyc_done(cyc_done),
    .cyc_strobe(cyc_strobe), .seq_state(seq_state), .hit_vec(hit_vec),
    .pcb_hit(pcb_hit), .use_rdy(use_rdy), .ws_res(ws_res), .addr_q(addr_q)
);

// File: tb/chip_select_decoder_bench.sv
module chip_select_decoder_bench;

    localparam int LIMIT = 20;
    localparam int NV    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_chan = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_wdata = '0;
    logic [11:0] pcb_base = 12'h021;
    logic        pcb_io = 1'b0;
    logic        cyc_strobe = 1'b0;
    logic [19:0] cyc_addr = '0;
    logic        cyc_io = 1'b0;
    logic        ext_ready = 1'b0;
    logic [9:0]  cs_n;
    logic        cyc_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    chip_select_decoder u_chip_select_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .pcb_base(pcb_base),
        .pcb_io(pcb_io), .cyc_strobe(cyc_strobe), .cyc_addr(cyc_addr),
        .cyc_io(cyc_io), .ext_ready(ext_ready), .cs_n(cs_n), .cyc_done(cyc_done)
    );

    // {addr, io, ready_after (99 = never), expected hits, expected clocks (0 = never ends), req}
    localparam logic [50:0] VEC [NV] = '{
        {20'h00000, 1'b0, 8'd99, 10'h001, 8'd3, 4'd3},   // R3 lower edge of ch0
        {20'h03FFF, 1'b0, 8'd99, 10'h003, 8'd6, 4'd8},   // R6 R8 overlap, max of 2 and 5
        {20'h04000, 1'b0, 8'd99, 10'h002, 8'd6, 4'd3},   // R3 just past ch0 upper edge
        {20'h03000, 1'b0, 8'd0,  10'h007, 8'd4, 4'd7},   // R7 min wait 2 then READY
        {20'h03000, 1'b0, 8'd8,  10'h007, 8'd9, 4'd7},   // R7 READY late
        {20'h02100, 1'b0, 8'd0,  10'h000, 8'd2, 4'd10},  // R10 inside peripheral window
        {20'h020FF, 1'b0, 8'd99, 10'h003, 8'd6, 4'd10},  // R10 byte below window
        {20'h02200, 1'b0, 8'd99, 10'h003, 8'd6, 4'd10},  // R10 byte above window
        {20'h00150, 1'b1, 8'd0,  10'h008, 8'd3, 4'd4},   // R4 I/O window ch3
        {20'h00150, 1'b0, 8'd99, 10'h001, 8'd3, 4'd4},   // R4 same address in memory
        {20'h000FF, 1'b1, 8'd0,  10'h000, 8'd2, 4'd9},   // R9 I/O miss
        {20'h08000, 1'b0, 8'd0,  10'h000, 8'd2, 4'd5},   // R5 inverted limits
        {20'h10000, 1'b0, 8'd0,  10'h000, 8'd2, 4'd5},   // R5 enable clear
        {20'hFFC00, 1'b0, 8'd0,  10'h200, 8'd5, 4'd1},   // R1 boot channel kept
        {20'h40000, 1'b0, 8'd99, 10'h040, 8'd1, 4'd2},   // R2 zero wait; field 3 ignored
        {20'h03000, 1'b0, 8'd99, 10'h007, 8'd0, 4'd7}    // R7 READY never: no end
    };

    task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] ch, input logic [1:0] fld, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = ch; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_cycle(input logic [19:0] a, input logic io, input int rdy_after,
                             input logic [9:0] exp_hits, input int exp_n, input int req);
        int n;
        bit held;
        logic [9:0] first_cs;
        n = 0;
        held = 1'b1;
        first_cs = '1;
        @(negedge clk);
        cyc_addr = a; cyc_io = io; cyc_strobe = 1'b1; ext_ready = (rdy_after == 0);
        @(posedge clk);
        @(negedge clk);
        cyc_strobe = 1'b0;
        for (int k = 1; k <= LIMIT; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) first_cs = cs_n;
            else if (cs_n !== first_cs) held = 1'b0;
            if (cyc_done) begin
                n = k;
                break;
            end
            if (k >= rdy_after) ext_ready = 1'b1;
        end
        chk(first_cs === ~exp_hits, req, 32'(first_cs), 32'(~exp_hits));
        chk(held, 11, 32'(held), 32'd1);  // R11 selects held through the cycle
        chk(n == exp_n, req, n, exp_n);
        if (n == 0) begin
            ext_ready = 1'b1;
            while (!cyc_done) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk((&cs_n) && !cyc_done, 11, {21'd0, cyc_done, cs_n}, 32'h3FF);  // R11 release
        ext_ready = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(&cs_n, 1, 32'(cs_n), 32'h3FF);
        chk(!cyc_done, 1, 32'(cyc_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 boot channel before configuration; R9 miss below it
        run_cycle(20'hFFC00, 1'b0, 0,  10'h200, 5, 1);
        run_cycle(20'hFFFFF, 1'b0, 0,  10'h200, 5, 1);
        run_cycle(20'hFFBFF, 1'b0, 0,  10'h000, 2, 9);
        run_cycle(20'h0FFFF, 1'b1, 0,  10'h000, 2, 4);

        // R2 configuration
        wr(4'd0, 2'd0, 16'h000); wr(4'd0, 2'd1, 16'h00F); wr(4'd0, 2'd2, 16'h0021);
        wr(4'd1, 2'd0, 16'h008); wr(4'd1, 2'd1, 16'h01F); wr(4'd1, 2'd2, 16'h0051);
        wr(4'd2, 2'd0, 16'h00C); wr(4'd2, 2'd1, 16'h00C); wr(4'd2, 2'd2, 16'h0045);
        wr(4'd3, 2'd0, 16'h004); wr(4'd3, 2'd1, 16'h007); wr(4'd3, 2'd2, 16'h0017);
        wr(4'd4, 2'd0, 16'h020); wr(4'd4, 2'd1, 16'h010); wr(4'd4, 2'd2, 16'h0001);
        wr(4'd5, 2'd0, 16'h040); wr(4'd5, 2'd1, 16'h040); wr(4'd5, 2'd2, 16'h0000);
        wr(4'd6, 2'd0, 16'h100); wr(4'd6, 2'd1, 16'h100); wr(4'd6, 2'd2, 16'h0001);
        wr(4'd6, 2'd3, 16'h0000);  // R2 field code 3 has no effect

        for (int v = 0; v < NV; v++) begin
            run_cycle(VEC[v][50:31], VEC[v][30], int'(VEC[v][29:22]),
                      VEC[v][21:12], int'(VEC[v][11:4]), int'(VEC[v][3:0]));
        end

        // R12 strobe during an active cycle is ignored
        @(negedge clk);
        cyc_addr = 20'h00000; cyc_io = 1'b0; cyc_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cyc_addr = 20'h04000; cyc_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc_strobe = 1'b0;
        chk(cs_n === ~10'h001, 12, 32'(cs_n), 32'(~10'h001));
        @(posedge clk);
        @(negedge clk);
        chk(cyc_done === 1'b1, 12, 32'(cyc_done), 32'd1);
        repeat (4) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk((&cs_n) && !cyc_done, 12, {21'd0, cyc_done, cs_n}, 32'h3FF);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule